// File: doc/BRIEF.md
# Iterative Backward Slice Detector

This block learns which instructions feed memory addresses and grows that set backwards by one producer level each time a loop body runs again. It sits in a processor front end with two connections. A fetch-side query takes up to two instruction pointers per cycle and returns one "known address producer" bit for each. A rename-side port takes up to two renamed instructions per cycle. Each carries its kind, its pointer, the bit it received at fetch, one destination register and up to three source registers.

Inside, a table indexed by physical register remembers the last writer of each register: its pointer, its fetch bit and whether it was a memory operation. A consumer that is a load, a store, or an instruction already marked as an address producer looks up the writers of its relevant sources. Every writer that was not marked and is not itself a memory operation is queued. The queue feeds a tag-only, two-way set-associative table one pointer per cycle, away from the rename path. An instruction that is already in flight keeps the classification it received at fetch. Only later fetches of the same pointer see the new mark.

Top module: `addrSliceLearner`

## Requirements
- R1: After reset the slice table is empty: every fetch query returns 0, and a source register never written since reset yields no producer.
- R2: A learned pointer is found by a fetch query whose pointer matches both the set index (bits [5:0]) and the tag (bits [31:6]). A pointer that differs in either field does not hit.
- R3: A consumer triggers producer lookup when its kind is load (kind code 1) or store (kind code 2), or when its kind is execute (code 0 or 3) and its fetch bit is 1. An execute consumer with fetch bit 0 inserts nothing.
- R4: For a store, only sources flagged as address operands are looked up. Its data sources insert nothing.
- R5: A producer is inserted only if it was an execute instruction whose fetch bit was 0 at its own rename. Loads, stores and already-marked producers are never inserted.
- R6: The dependency table keeps the last writer of each register. When both lanes write the same register in one cycle, lane 1 wins. A lane 1 source reads a register written by lane 0 in the same cycle as that lane 0 instruction.
- R7: With an empty insertion queue, a producer found by a consumer renamed in cycle t misses at fetch in cycle t+1 and hits from cycle t+2 onward.
- R8: Each set holds two pointers. An insert fills an invalid way first, otherwise the least recently used way. A fetch hit or an insert makes that way the most recently used.
- R9: Insertions that target the same set in one cycle all land. A pointer already in the table, or queued twice, is not inserted again and does not change the set's recency.
- R10: A source whose valid flag is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetchValid | input | LANES (2) | Query enable per fetch lane |
| fetchIp | input | LANES×IP_W (2×32) | Instruction pointer per fetch lane |
| fetchHit | output | LANES (2) | Pointer is a known address producer |
| renValid | input | LANES (2) | Renamed instruction present per lane |
| renKind | input | LANES×2 | 0 execute, 1 load, 2 store, 3 execute |
| renIp | input | LANES×IP_W (2×32) | Pointer of the renamed instruction |
| renHit | input | LANES (2) | Fetch bit carried with the instruction |
| renDstValid | input | LANES (2) | Instruction writes a destination register |
| renDst | input | LANES×REG_W (2×6) | Physical destination register |
| renSrcValid | input | LANES×SRCS (2×3) | Source slot in use |
| renSrc | input | LANES×SRCS×REG_W (2×3×6) | Physical source registers |
| renSrcAddr | input | LANES×SRCS (2×3) | Source forms a store address |

## Verification
The consumer side is swept over every combination of kind, fetch bit and address-operand flag. This separates the three lookup triggers from each other and the address sources of a store from its data sources. The producer side is swept over kind and fetch bit, which shows the insertion filter apart from the lookup trigger. Register rewrites, same-cycle writes by both lanes and same-cycle forwarding from lane 0 to lane 1 check which writer the table returns. Sequences of three pointers in one set, with and without a refreshing fetch and with repeated insertion attempts, tell correct victim selection apart from duplicate insertion and lost same-set insertions.

// File: rtl/sliceLearnPkg.sv
package sliceLearnPkg;

  typedef enum logic [1:0] {
    KIND_EXEC  = 2'd0,
    KIND_LOAD  = 2'd1,
    KIND_STORE = 2'd2,
    KIND_OTHER = 2'd3
  } instKind_e;

  // strobes from the insertion control to the tag datapath
  typedef struct packed {
    logic doInsert;
    logic victimWay;
  } tagCtl_t;

endpackage

// File: rtl/sliceDepTrack.sv
module sliceDepTrack import sliceLearnPkg::*; #(
  parameter int IP_W  = 32,
  parameter int PREGS = 64,
  parameter int LANES = 2,
  parameter int SRCS  = 3,
  localparam int REG_W = $clog2(PREGS),
  localparam int CANDS = LANES * SRCS
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [LANES-1:0]                    renValid,
  input  logic [LANES-1:0][1:0]               renKind,
  input  logic [LANES-1:0][IP_W-1:0]          renIp,
  input  logic [LANES-1:0]                    renHit,
  input  logic [LANES-1:0]                    renDstValid,
  input  logic [LANES-1:0][REG_W-1:0]         renDst,
  input  logic [LANES-1:0][SRCS-1:0]          renSrcValid,
  input  logic [LANES-1:0][SRCS-1:0][REG_W-1:0] renSrc,
  input  logic [LANES-1:0][SRCS-1:0]          renSrcAddr,
  output logic [CANDS-1:0]                    candValid,
  output logic [CANDS-1:0][IP_W-1:0]          candIp
);

  logic [IP_W-1:0]  entIp [PREGS];
  logic [PREGS-1:0] entVld;
  logic [PREGS-1:0] entHit;
  logic [PREGS-1:0] entMem;

  logic [LANES-1:0] isMem;
  logic [LANES-1:0] doLook;
  logic [LANES-1:0][SRCS-1:0][IP_W-1:0] prodIp;
  logic [LANES-1:0][SRCS-1:0] prodVld, prodHit, prodMem;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      isMem[l]  = (renKind[l] == KIND_LOAD) || (renKind[l] == KIND_STORE);
      doLook[l] = renValid[l] && (isMem[l] || renHit[l]);
    end
  end

  // producer read with in-group forwarding from older lanes
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      for (int s = 0; s < SRCS; s++) begin
        prodIp[l][s]  = entIp[renSrc[l][s]];
        prodVld[l][s] = entVld[renSrc[l][s]];
        prodHit[l][s] = entHit[renSrc[l][s]];
        prodMem[l][s] = entMem[renSrc[l][s]];
        for (int j = 0; j < LANES; j++) begin
          if (j < l && renValid[j] && renDstValid[j] && renDst[j] == renSrc[l][s]) begin
            prodIp[l][s]  = renIp[j];
            prodVld[l][s] = 1'b1;
            prodHit[l][s] = renHit[j];
            prodMem[l][s] = isMem[j];
          end
        end
      end
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      for (int s = 0; s < SRCS; s++) begin
        candValid[l*SRCS+s] = doLook[l] && renSrcValid[l][s]
                              && ((renKind[l] != KIND_STORE) || renSrcAddr[l][s])
                              && prodVld[l][s] && !prodHit[l][s] && !prodMem[l][s];
        candIp[l*SRCS+s]    = prodIp[l][s];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entVld <= '0;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (renValid[l] && renDstValid[l]) entVld[renDst[l]] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (renValid[l] && renDstValid[l]) begin
        entIp[renDst[l]]  <= renIp[l];
        entHit[renDst[l]] <= renHit[l];
        entMem[renDst[l]] <= isMem[l];
      end
    end
  end

  logic wr0Only;
  assign wr0Only = renValid[0] && renDstValid[0]
                   && !(renValid[1] && renDstValid[1] && renDst[1] == renDst[0]);

  // R6: a register written only by lane 0 reads back that writer next cycle
  p_last_writer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr0Only) && renSrc[0][0] == $past(renDst[0]))
      |-> (prodVld[0][0] && prodIp[0][0] == $past(renIp[0])));

endmodule

// File: rtl/sliceInsertCtl.sv
module sliceInsertCtl import sliceLearnPkg::*; #(
  parameter int IP_W  = 32,
  parameter int DEPTH = 8,
  parameter int CANDS = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [CANDS-1:0]           candValid,
  input  logic [CANDS-1:0][IP_W-1:0] candIp,
  output logic [IP_W-1:0]            headIp,
  input  logic                       probePresent,
  input  logic [1:0]                 probeValid,
  input  logic                       probeLru,
  output tagCtl_t                    ctl
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + CANDS + 1);

  logic [IP_W-1:0]  qMem [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [CW-1:0]    cnt, room, pushN;
  logic [CANDS-1:0] keep, accept;
  logic [CW-1:0]    offs [CANDS];
  logic             pop;

  // drop in-cycle duplicates, then pack survivors into free slots
  always_comb begin
    room  = CW'(DEPTH) - cnt;
    pushN = '0;
    for (int k = 0; k < CANDS; k++) begin
      keep[k] = candValid[k];
      for (int j = 0; j < CANDS; j++) begin
        if (j < k && candValid[j] && candIp[j] == candIp[k]) keep[k] = 1'b0;
      end
      offs[k]   = pushN;
      accept[k] = keep[k] && (pushN < room);
      if (accept[k]) pushN = pushN + CW'(1);
    end
  end

  assign wrPtr  = rdPtr + cnt[PTR_W-1:0];
  assign headIp = qMem[rdPtr];
  assign pop    = (cnt != '0);

  always_comb begin
    ctl.doInsert  = pop && !probePresent;
    ctl.victimWay = !probeValid[0] ? 1'b0 : (!probeValid[1] ? 1'b1 : probeLru);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      rdPtr <= '0;
    end else begin
      cnt   <= cnt + pushN - CW'(pop);
      rdPtr <= rdPtr + PTR_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < CANDS; k++) begin
      if (accept[k]) qMem[wrPtr + offs[k][PTR_W-1:0]] <= candIp[k];
    end
  end

  // R9: queue occupancy never exceeds its storage
  p_queue_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

endmodule

// File: rtl/sliceTagStore.sv
module sliceTagStore import sliceLearnPkg::*; #(
  parameter int IP_W    = 32,
  parameter int ENTRIES = 128,
  parameter int LANES   = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [LANES-1:0]           fetchValid,
  input  logic [LANES-1:0][IP_W-1:0] fetchIp,
  output logic [LANES-1:0]           fetchHit,
  input  logic [IP_W-1:0]            probeIp,
  output logic                       probePresent,
  output logic [1:0]                 probeValid,
  output logic                       probeLru,
  input  tagCtl_t                    ctl
);

  localparam int WAYS  = 2;
  localparam int SETS  = ENTRIES / WAYS;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = IP_W - IDX_W;
  localparam int VT_W  = $clog2(ENTRIES + 1);

  logic [TAG_W-1:0] tagMem [SETS][WAYS];
  logic [WAYS-1:0]  vld [SETS];
  logic [SETS-1:0]  lruBits;   // way to replace next

  logic [IDX_W-1:0] fIdx [LANES];
  logic [TAG_W-1:0] fTag [LANES];
  logic [LANES-1:0] fM0, fM1, fWay;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      fIdx[l]     = fetchIp[l][IDX_W-1:0];
      fTag[l]     = fetchIp[l][IP_W-1:IDX_W];
      fM0[l]      = vld[fIdx[l]][0] && tagMem[fIdx[l]][0] == fTag[l];
      fM1[l]      = vld[fIdx[l]][1] && tagMem[fIdx[l]][1] == fTag[l];
      fetchHit[l] = fetchValid[l] && (fM0[l] || fM1[l]);
      fWay[l]     = !fM0[l];
    end
  end

  logic [IDX_W-1:0] pIdx;
  logic [TAG_W-1:0] pTag;
  assign pIdx         = probeIp[IDX_W-1:0];
  assign pTag         = probeIp[IP_W-1:IDX_W];
  assign probePresent = (vld[pIdx][0] && tagMem[pIdx][0] == pTag)
                     || (vld[pIdx][1] && tagMem[pIdx][1] == pTag);
  assign probeValid   = vld[pIdx];
  assign probeLru     = lruBits[pIdx];

  // insertion is applied last so it takes recency over fetch hits
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld[s] <= '0;
      lruBits <= '0;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (fetchHit[l]) lruBits[fIdx[l]] <= !fWay[l];
      end
      if (ctl.doInsert) begin
        vld[pIdx][ctl.victimWay] <= 1'b1;
        lruBits[pIdx]            <= !ctl.victimWay;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.doInsert) tagMem[pIdx][ctl.victimWay] <= pTag;
  end

  logic [VT_W-1:0] validTotal;
  always_comb begin
    validTotal = '0;
    for (int s = 0; s < SETS; s++) begin
      validTotal = validTotal + VT_W'(vld[s][0]) + VT_W'(vld[s][1]);
    end
  end

  // R2: occupancy changes only through an insert strobe
  p_valid_by_insert_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (validTotal != $past(validTotal)) |-> $past(ctl.doInsert));

  // R2: an inserted pointer is present on the next cycle
  p_insert_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctl.doInsert) && probeIp == $past(probeIp)) |-> probePresent);

  // R8: after an insert the set points away from the filled way
  p_lru_turns_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctl.doInsert) && pIdx == $past(pIdx)) |-> (probeLru != $past(ctl.victimWay)));

  // R9: the two ways of a set never hold the same pointer
  for (genvar s = 0; s < SETS; s++) begin : g_setChk
    p_distinct_ways_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (vld[s] == 2'b11) |-> (tagMem[s][0] != tagMem[s][1]));
  end

endmodule

// File: rtl/addrSliceLearner.sv
module addrSliceLearner import sliceLearnPkg::*; #(
  parameter int IP_W          = 32,
  parameter int SLICE_ENTRIES = 128,
  parameter int PHYS_REGS     = 64,
  parameter int LANES         = 2,
  parameter int SRCS          = 3,
  parameter int QUEUE_DEPTH   = 8,
  localparam int REG_W = $clog2(PHYS_REGS)
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [LANES-1:0]                      fetchValid,
  input  logic [LANES-1:0][IP_W-1:0]            fetchIp,
  output logic [LANES-1:0]                      fetchHit,
  input  logic [LANES-1:0]                      renValid,
  input  logic [LANES-1:0][1:0]                 renKind,
  input  logic [LANES-1:0][IP_W-1:0]            renIp,
  input  logic [LANES-1:0]                      renHit,
  input  logic [LANES-1:0]                      renDstValid,
  input  logic [LANES-1:0][REG_W-1:0]           renDst,
  input  logic [LANES-1:0][SRCS-1:0]            renSrcValid,
  input  logic [LANES-1:0][SRCS-1:0][REG_W-1:0] renSrc,
  input  logic [LANES-1:0][SRCS-1:0]            renSrcAddr
);

  localparam int CANDS = LANES * SRCS;

  logic [CANDS-1:0]           candValid;
  logic [CANDS-1:0][IP_W-1:0] candIp;
  logic [IP_W-1:0]            headIp;
  logic                       probePresent;
  logic [1:0]                 probeValid;
  logic                       probeLru;
  tagCtl_t                    tagCtl;

  sliceDepTrack #(.IP_W(IP_W), .PREGS(PHYS_REGS), .LANES(LANES), .SRCS(SRCS)) u_depTrack (
    .clk(clk), .rst_n(rst_n),
    .renValid(renValid), .renKind(renKind), .renIp(renIp), .renHit(renHit),
    .renDstValid(renDstValid), .renDst(renDst),
    .renSrcValid(renSrcValid), .renSrc(renSrc), .renSrcAddr(renSrcAddr),
    .candValid(candValid), .candIp(candIp)
  );

  sliceInsertCtl #(.IP_W(IP_W), .DEPTH(QUEUE_DEPTH), .CANDS(CANDS)) u_insertCtl (
    .clk(clk), .rst_n(rst_n),
    .candValid(candValid), .candIp(candIp),
    .headIp(headIp), .probePresent(probePresent),
    .probeValid(probeValid), .probeLru(probeLru),
    .ctl(tagCtl)
  );

  sliceTagStore #(.IP_W(IP_W), .ENTRIES(SLICE_ENTRIES), .LANES(LANES)) u_tagStore (
    .clk(clk), .rst_n(rst_n),
    .fetchValid(fetchValid), .fetchIp(fetchIp), .fetchHit(fetchHit),
    .probeIp(headIp), .probePresent(probePresent),
    .probeValid(probeValid), .probeLru(probeLru),
    .ctl(tagCtl)
  );

endmodule

// File: tb/addrSliceLearner_bench.sv
`timescale 1ns/1ps
module addrSliceLearner_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0]            fetchValid;
  logic [1:0][31:0]      fetchIp;
  logic [1:0]            fetchHit;
  logic [1:0]            renValid;
  logic [1:0][1:0]       renKind;
  logic [1:0][31:0]      renIp;
  logic [1:0]            renHit;
  logic [1:0]            renDstValid;
  logic [1:0][5:0]       renDst;
  logic [1:0][2:0]       renSrcValid;
  logic [1:0][2:0][5:0]  renSrc;
  logic [1:0][2:0]       renSrcAddr;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  addrSliceLearner u_addrSliceLearner (
    .clk(clk), .rst_n(rst_n),
    .fetchValid(fetchValid), .fetchIp(fetchIp), .fetchHit(fetchHit),
    .renValid(renValid), .renKind(renKind), .renIp(renIp), .renHit(renHit),
    .renDstValid(renDstValid), .renDst(renDst),
    .renSrcValid(renSrcValid), .renSrc(renSrc), .renSrcAddr(renSrcAddr)
  );

  function automatic logic [31:0] mk(int t, int s);
    return {26'(t), 6'(s)};
  endfunction

  task automatic clearRen();
    renValid = '0; renKind = '0; renIp = '0; renHit = '0;
    renDstValid = '0; renDst = '0; renSrcValid = '0; renSrc = '0; renSrcAddr = '0;
  endtask

  task automatic setLane(int l, int kind, logic [31:0] ip, logic hit, logic dv, int dst);
    renValid[l] = 1'b1; renKind[l] = 2'(kind); renIp[l] = ip;
    renHit[l] = hit; renDstValid[l] = dv; renDst[l] = 6'(dst);
  endtask

  task automatic setSrc(int l, int s, int r, logic af);
    renSrcValid[l][s] = 1'b1; renSrc[l][s] = 6'(r); renSrcAddr[l][s] = af;
  endtask

  task automatic tick();
    @(negedge clk);
    clearRen();
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chkHit(int lane, logic [31:0] ip, logic expv, string req);
    fetchValid[lane] = 1'b1; fetchIp[lane] = ip;
    #1;
    total++;
    if (fetchHit[lane] !== expv) begin
      bad++;
      $display("FAIL %s ip=%h actual=%0b expected=%0b", req, ip, fetchHit[lane], expv);
    end
    fetchValid[lane] = 1'b0;
  endtask

  task automatic touch(logic [31:0] ip);
    fetchValid[0] = 1'b1; fetchIp[0] = ip;
    @(negedge clk);
    fetchValid[0] = 1'b0;
  endtask

  task automatic learn(logic [31:0] ip, int r);
    setLane(0, 0, ip, 1'b0, 1'b1, r); tick();
    setLane(0, 1, mk(999, 63), 1'b0, 1'b0, 0); setSrc(0, 0, r, 1'b0); tick();
    idle(3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    fetchValid = '0; fetchIp = '0; clearRen();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: empty after reset
    for (int k = 0; k < 4; k++) chkHit(k % 2, mk(k, k), 1'b0, "R1 empty");

    // R7 / R2: latency and index/tag match
    setLane(0, 0, mk(1, 1), 1'b0, 1'b1, 3); tick();
    setLane(0, 1, mk(900, 63), 1'b0, 1'b0, 0); setSrc(0, 0, 3, 1'b0); tick();
    chkHit(0, mk(1, 1), 1'b0, "R7 too early");
    @(negedge clk);
    chkHit(0, mk(1, 1), 1'b1, "R7 visible");
    chkHit(1, mk(2, 1), 1'b0, "R2 tag differs");
    chkHit(0, mk(1, 2), 1'b0, "R2 index differs");

    // R3 / R4: consumer kind x fetch bit x address flag
    for (int kind = 0; kind < 3; kind++)
      for (int hit = 0; hit < 2; hit++)
        for (int af = 0; af < 2; af++) begin
          int i;
          logic expv;
          i = kind * 4 + hit * 2 + af;
          setLane(0, 0, mk(10 + i, 2 + i), 1'b0, 1'b1, 10 + i); tick();
          setLane(0, kind, mk(500 + i, 63), 1'(hit), 1'b0, 0); setSrc(0, 0, 10 + i, 1'(af)); tick();
          idle(3);
          expv = (kind == 1) || (kind == 2 && af == 1) || (kind == 0 && hit == 1);
          chkHit(0, mk(10 + i, 2 + i), expv, (kind == 2) ? "R4 store operand" : "R3 lookup trigger");
        end

    // R3: kind code 3 behaves as execute
    setLane(0, 0, mk(14, 14), 1'b0, 1'b1, 22); tick();
    setLane(1, 3, mk(600, 63), 1'b1, 1'b0, 0); setSrc(1, 2, 22, 1'b0); tick();
    idle(3);
    chkHit(1, mk(14, 14), 1'b1, "R3 kind 3 marked");

    // R5: producer kind x producer fetch bit
    for (int pk = 0; pk < 3; pk++)
      for (int ph = 0; ph < 2; ph++) begin
        int j;
        j = pk * 2 + ph;
        setLane(0, pk, mk(40 + j, 20 + j), 1'(ph), 1'b1, 30 + j); tick();
        setLane(0, 1, mk(700 + j, 63), 1'b0, 1'b0, 0); setSrc(0, 0, 30 + j, 1'b0); tick();
        idle(3);
        chkHit(1, mk(40 + j, 20 + j), (pk == 0 && ph == 0), "R5 producer filter");
      end

    // R6: rewrite, same-cycle double write, same-cycle forwarding
    setLane(0, 0, mk(60, 30), 1'b0, 1'b1, 40); tick();
    setLane(0, 0, mk(61, 31), 1'b0, 1'b1, 40); tick();
    setLane(0, 1, mk(800, 63), 1'b0, 1'b0, 0); setSrc(0, 0, 40, 1'b0); tick();
    idle(3);
    chkHit(0, mk(61, 31), 1'b1, "R6 last writer");
    chkHit(0, mk(60, 30), 1'b0, "R6 old writer");
    setLane(0, 0, mk(62, 32), 1'b0, 1'b1, 41);
    setLane(1, 0, mk(63, 33), 1'b0, 1'b1, 41); tick();
    setLane(0, 1, mk(801, 63), 1'b0, 1'b0, 0); setSrc(0, 0, 41, 1'b0); tick();
    idle(3);
    chkHit(0, mk(63, 33), 1'b1, "R6 lane1 wins");
    chkHit(0, mk(62, 32), 1'b0, "R6 lane0 overwritten");
    setLane(0, 0, mk(64, 34), 1'b0, 1'b1, 42);
    setLane(1, 1, mk(802, 63), 1'b0, 1'b0, 0); setSrc(1, 1, 42, 1'b0); tick();
    idle(3);
    chkHit(1, mk(64, 34), 1'b1, "R6 in-group forward");

    // R8: replacement with and without a refreshing fetch
    learn(mk(70, 40), 43); learn(mk(71, 40), 44);
    touch(mk(70, 40));
    learn(mk(72, 40), 45);
    chkHit(0, mk(70, 40), 1'b1, "R8 refreshed kept");
    chkHit(0, mk(71, 40), 1'b0, "R8 lru evicted");
    chkHit(0, mk(72, 40), 1'b1, "R8 new entry");
    learn(mk(73, 41), 46); learn(mk(74, 41), 47); learn(mk(75, 41), 48);
    chkHit(0, mk(73, 41), 1'b0, "R8 oldest evicted");
    chkHit(0, mk(74, 41), 1'b1, "R8 second kept");
    chkHit(0, mk(75, 41), 1'b1, "R8 third present");

    // R9: same-set pair in one cycle
    setLane(0, 0, mk(80, 42), 1'b0, 1'b1, 49);
    setLane(1, 0, mk(81, 42), 1'b0, 1'b1, 50); tick();
    setLane(0, 1, mk(803, 63), 1'b0, 1'b0, 0); setSrc(0, 0, 49, 1'b0);
    setLane(1, 1, mk(804, 63), 1'b0, 1'b0, 0); setSrc(1, 0, 50, 1'b0); tick();
    idle(4);
    chkHit(0, mk(80, 42), 1'b1, "R9 same set first");
    chkHit(1, mk(81, 42), 1'b1, "R9 same set second");

    // R9: three sources of one load, plus duplicates not re-inserted
    setLane(0, 0, mk(82, 43), 1'b0, 1'b1, 51);
    setLane(1, 0, mk(83, 44), 1'b0, 1'b1, 52); tick();
    setLane(0, 0, mk(84, 46), 1'b0, 1'b1, 53); tick();
    setLane(0, 1, mk(805, 63), 1'b0, 1'b0, 0);
    setSrc(0, 0, 51, 1'b0); setSrc(0, 1, 52, 1'b0); setSrc(0, 2, 53, 1'b0); tick();
    idle(5);
    chkHit(0, mk(82, 43), 1'b1, "R9 multi source a");
    chkHit(0, mk(83, 44), 1'b1, "R9 multi source b");
    chkHit(0, mk(84, 46), 1'b1, "R9 multi source c");
    learn(mk(90, 45), 54); learn(mk(91, 45), 55);
    setLane(0, 1, mk(806, 63), 1'b0, 1'b0, 0); setSrc(0, 0, 54, 1'b0);
    setLane(1, 1, mk(807, 63), 1'b0, 1'b0, 0); setSrc(1, 0, 54, 1'b0); tick();
    setLane(0, 1, mk(808, 63), 1'b0, 1'b0, 0); setSrc(0, 1, 54, 1'b0); tick();
    idle(4);
    learn(mk(92, 45), 56);
    chkHit(0, mk(90, 45), 1'b0, "R9 duplicate left recency");
    chkHit(0, mk(91, 45), 1'b1, "R9 duplicate no evict");
    chkHit(0, mk(92, 45), 1'b1, "R9 after duplicate");

    // R10: unused source slot; R1: never-written register
    setLane(0, 0, mk(100, 50), 1'b0, 1'b1, 57); tick();
    setLane(0, 1, mk(809, 63), 1'b0, 1'b0, 0);
    renSrc[0][0] = 6'd57; renSrcAddr[0][0] = 1'b0;
    setSrc(0, 1, 60, 1'b0); tick();
    idle(3);
    chkHit(0, mk(100, 50), 1'b0, "R10 invalid source");
    chkHit(0, mk(0, 0), 1'b0, "R1 unwritten register");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule